// File: doc/BRIEF.md
# Address-Event Receiver with Arrival Timestamps

This block sits at the receiving end of a four-phase, return-to-zero address-event link. A sender puts an address and a polarity bit on the bus and raises request. The receiver passes request through a two-flop synchronizer. One cycle after the synchronized rise it captures the bus and the current value of a free-running cycle counter. The captured word goes into an event FIFO, and only then does the receiver raise acknowledge. The bus never carries time. Each event's timestamp is the cycle in which the receiver captured it.

The handshake has three states. `HS_IDLE` waits for the synchronized request and takes transition *req_seen* to `HS_SEEN`. `HS_SEEN` holds while the FIFO is full (transition *stall*). It leaves through transition *capture*, which writes the word into the FIFO and moves to `HS_ACK`. `HS_ACK` drives acknowledge high and stays there while request is still high (transition *hold*). It returns to `HS_IDLE` through transition *release* once the synchronized request is low. A full FIFO therefore throttles the sender only by delaying acknowledge, and no event is dropped. Downstream logic drains the FIFO in arrival order through a valid/ready port.

Top module: `aer_event_receiver`

## Requirements
- R1: After reset, `ev_ack` is low and `out_valid` is low.
- R2: When the FIFO has room, `ev_ack` rises after the 4th rising clock edge that follows the rise of `ev_req`. The edges are two synchronizer stages, *req_seen* and *capture*. Acknowledge never rises without a capture in the cycle before.
- R3: `ev_ack` stays high for as long as `ev_req` is held high. After `ev_req` falls, `ev_ack` goes low after the 3rd rising clock edge.
- R4: The stored word has polarity in bit 0, the address in bits ADDR_W:1 and the timestamp in the top TS_W bits. Address and polarity are the bus values at the capture edge, and later bus changes do not affect the stored word.
- R5: The timestamp counter is cleared by reset and advances by one on every clock edge after reset, wrapping modulo 2^TS_W. An event's timestamp is the counter value just before its capture edge.
- R6: While the FIFO holds DEPTH words, a pending request is not acknowledged and nothing is written. Once a word is read out, the pending event is captured and acknowledged, and no event is lost.
- R7: Words leave in arrival order. A word is removed on a clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` holds steady.
- R8: A request held high after acknowledge produces exactly one stored event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_req | input | 1 | Request from the sender (asynchronous) |
| ev_addr | input | ADDR_W | Event address on the bus |
| ev_pol | input | 1 | Event polarity on the bus |
| ev_ack | output | 1 | Acknowledge to the sender |
| out_valid | output | 1 | FIFO holds at least one word |
| out_ready | input | 1 | Consumer accepts the head word |
| out_data | output | TS_W+ADDR_W+1 | Head word {timestamp, address, polarity} |

## Verification
Some rules are checked by assertions on every cycle:
- acknowledge only ever follows a capture;
- acknowledge holds while request is high and drops after request is seen low;
- a full FIFO blocks both acknowledge and writes;
- the timestamp counter steps by one each cycle;
- the FIFO head stays steady under a stall.

Other behaviour needs the bench's directed scenarios to show it: the exact edge counts from request to acknowledge, the field layout and timestamp values of the stored words, arrival ordering, single capture under a held request, and resumption of a stalled event once a word is read.

// File: rtl/aer_rx_pkg.sv
package aer_rx_pkg;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_SEEN = 2'd1,
        HS_ACK  = 2'd2
    } hs_state_t;

endpackage

// File: rtl/aer_req_sync.sv
module aer_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/aer_ts_counter.sv
module aer_ts_counter #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] ts
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ts <= '0;
        else        ts <= ts + TS_W'(1);
    end

    AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ts == $past(ts) + TS_W'(1)); // R5
endmodule

// File: rtl/aer_evt_fifo.sv
module aer_evt_fifo #(
    parameter int W     = 47,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         full,
    output logic         rd_valid,
    input  logic         rd_ready,
    output logic [W-1:0] rd_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_rd;

    assign full     = (count == CW'(DEPTH));
    assign rd_valid = (count != '0);
    assign do_rd    = rd_valid && rd_ready;
    assign rd_data  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_en && !full) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en && !full) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
            if (do_rd)          rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
            case ({wr_en && !full, do_rd})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full); // R6
    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R7
endmodule

// File: rtl/aer_hs_fsm.sv
module aer_hs_fsm
    import aer_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic fifo_full,
    output logic push,
    output logic ack
);
    hs_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= HS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            HS_IDLE: if (req_s)      state_nx = HS_SEEN;   // req_seen
            HS_SEEN: if (!fifo_full) state_nx = HS_ACK;    // capture (else stall)
            HS_ACK:  if (!req_s)     state_nx = HS_IDLE;   // release (else hold)
            default:                 state_nx = HS_IDLE;
        endcase
    end

    always_comb begin
        push = 1'b0;
        ack  = 1'b0;
        unique case (state)
            HS_IDLE: ;
            HS_SEEN: push = !fifo_full;
            HS_ACK:  ack  = 1'b1;
            default: ;
        endcase
    end

    AST_ACK_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(push)); // R2
    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req_s) |=> ack); // R3
    AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !req_s) |=> !ack); // R3
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_s && !ack && fifo_full) |=> !ack); // R6
endmodule

// File: rtl/aer_event_receiver.sv
module aer_event_receiver #(
    parameter int ADDR_W = 14,
    parameter int TS_W   = 32,
    parameter int DEPTH  = 4,
    localparam int WORD_W = TS_W + ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_req,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              ev_pol,
    output logic              ev_ack,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);
    logic            req_s;
    logic            push;
    logic            fifo_full;
    logic [TS_W-1:0] ts_now;

    aer_req_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ev_req), .sync_out(req_s)
    );

    aer_ts_counter #(.TS_W(TS_W)) u_ts (
        .clk(clk), .rst_n(rst_n), .ts(ts_now)
    );

    aer_hs_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_s(req_s), .fifo_full(fifo_full),
        .push(push), .ack(ev_ack)
    );

    aer_evt_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_en(push), .wr_data({ts_now, ev_addr, ev_pol}),
        .full(fifo_full),
        .rd_valid(out_valid), .rd_ready(out_ready), .rd_data(out_data)
    );
endmodule

// File: tb/aer_event_receiver_tb.sv
module aer_event_receiver_tb;
    localparam int ADDR_W = 14;
    localparam int TS_W   = 32;
    localparam int DEPTH  = 4;
    localparam int WORD_W = TS_W + ADDR_W + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ev_req = 1'b0;
    logic [ADDR_W-1:0] ev_addr = '0;
    logic              ev_pol = 1'b0;
    logic              ev_ack;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [WORD_W-1:0] out_data;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] cyc = '0;
    logic [WORD_W-1:0] exp_q [0:31];
    int q_wr = 0;
    int q_rd = 0;

    always #5 clk = ~clk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= '0;
        else        cyc <= cyc + 32'd1;
    end

    aer_event_receiver #(.ADDR_W(ADDR_W), .TS_W(TS_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .ev_req(ev_req), .ev_addr(ev_addr), .ev_pol(ev_pol),
        .ev_ack(ev_ack), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Raise request, count edges to ack, record expected word; leave request high.
    task automatic raise_req(input logic [ADDR_W-1:0] a, input logic p, input int exp_edges);
        int n = 0;
        @(negedge clk);
        ev_addr = a;
        ev_pol  = p;
        ev_req  = 1'b1;
        while (!ev_ack && n < 60) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        if (exp_edges > 0) chk("R2 edges to ack", 64'(n), 64'(exp_edges));
        exp_q[q_wr] = {TS_W'(cyc - 32'd1), a, p};
        q_wr++;
        ev_addr = ~a;
        ev_pol  = ~p;
    endtask

    task automatic drop_req();
        int n = 0;
        ev_req = 1'b0;
        while (ev_ack && n < 60) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        chk("R3 edges to ack low", 64'(n), 64'd3);
    endtask

    task automatic send(input logic [ADDR_W-1:0] a, input logic p);
        raise_req(a, p, 4);
        drop_req();
    endtask

    task automatic pop_check(input string tag);
        @(negedge clk);
        chk({tag, " valid"}, 64'(out_valid), 64'd1);
        chk({tag, " word"}, 64'(out_data), 64'(exp_q[q_rd]));
        q_rd++;
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 ack after reset", 64'(ev_ack), 64'd0);
        chk("R1 valid after reset", 64'(out_valid), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_single();
        send(14'h1A5, 1'b1);
        pop_check("R4 R5 single word");
        chk("R7 empty after pop", 64'(out_valid), 64'd0);
    endtask

    task automatic t_held_req();
        raise_req(14'h0F0, 1'b0, 4);
        repeat (8) @(negedge clk);
        chk("R3 ack held with req high", 64'(ev_ack), 64'd1);
        drop_req();
        pop_check("R8 held word");
        chk("R8 only one event stored", 64'(out_valid), 64'd0);
    endtask

    task automatic t_order();
        send(14'h3FFF, 1'b0);
        repeat (3) @(negedge clk);
        send(14'h0001, 1'b1);
        send(14'h2222, 1'b0);
        pop_check("R7 order 0");
        pop_check("R7 order 1");
        pop_check("R7 order 2");
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH; i++) send(14'(16 * i + 3), i[0]);
        @(negedge clk);
        ev_addr = 14'h0ABC;
        ev_pol  = 1'b1;
        ev_req  = 1'b1;
        repeat (20) @(negedge clk);
        chk("R6 no ack while full", 64'(ev_ack), 64'd0);
        chk("R7 head stable while stalled", 64'(out_data), 64'(exp_q[q_rd]));
        pop_check("R6 first word under stall");
        begin
            int n = 0;
            while (!ev_ack && n < 20) begin
                @(posedge clk);
                n++;
                @(negedge clk);
            end
            chk("R6 ack after space frees", 64'(ev_ack), 64'd1);
            exp_q[q_wr] = {TS_W'(cyc - 32'd1), 14'h0ABC, 1'b1};
            q_wr++;
        end
        drop_req();
        for (int i = 0; i < DEPTH; i++) pop_check("R6 no loss drain");
        chk("R6 empty after drain", 64'(out_valid), 64'd0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        t_reset();
        t_single();
        t_held_req();
        t_order();
        t_full();
        summary();
    end
endmodule